// File: doc/BRIEF.md
# SMBus Configuration Register Slave

This block is a two-wire bus slave that lets a host read and write a small bank of configuration bytes. SCL and SDA are sampled by a fast system clock, start and stop conditions are detected from the sampled levels, and a byte-oriented state machine matches a 7-bit slave address, decodes a command byte and moves data between the bus and the register bank. SDA is driven only low, through an output enable, so it can be used with an external open-drain pad. Every register byte is also available as a parallel output for the rest of the chip.

The command byte selects one of two access styles. With its top bit set, the lower seven bits give a register offset for single-byte writes, two-byte (word) writes and single-byte reads. With its top bit clear, the transfer is a block access: a block write carries a byte count and then data from register 0 upward, and a block read first returns the bank size as a count and then register 0 upward, for as long as the host acknowledges. Reads use a repeated start after the command byte.

The state machine has the states ST_IDLE (no transfer), ST_ADDR (address byte), ST_CMD (command byte), ST_COUNT (block write count), ST_WDATA (write data), ST_ACK (slave acknowledge), ST_TX (read data out), ST_MACK (host acknowledge) and ST_HOLD (not addressed or done; waits for start or stop). Transitions: start from any state goes to ST_ADDR; stop from any state goes to ST_IDLE; after the eighth bit of a received byte, ST_ADDR goes to ST_ACK on a match (then ST_CMD for a write, ST_TX for a read) or to ST_HOLD on a mismatch; ST_CMD goes to ST_ACK then ST_COUNT (block) or ST_WDATA (indexed); ST_COUNT and ST_WDATA go to ST_ACK then ST_WDATA; ST_TX goes to ST_MACK after eight bits; ST_MACK returns to ST_TX on a host ACK in block mode, otherwise to ST_HOLD.

Top module: `smb_cfg_slave`

## Requirements
- R1: After reset every register byte reads 0x00 on the parallel outputs and SDA is not driven.
- R2: A byte whose upper seven bits equal the SLAVE_ADDR parameter is acknowledged (SDA low in the ninth clock); any other address is left unacknowledged and all further bytes are neither acknowledged nor acted on until the next start condition.
- R3: A command byte with bit 7 = 1 selects indexed access at the offset in bits 6:0; a byte write stores its data byte in that one register.
- R4: In indexed mode a second data byte is stored in the next register up (word write).
- R5: Command byte 0x00 (bit 7 = 0) selects block access; on a write the byte after the command is a count that is acknowledged and not stored, the data bytes go to register 0, 1, 2 … in order, and the host may stop after any whole byte.
- R6: A read after a repeated start in indexed mode returns the register at the command offset, MSB first, and then releases SDA whatever the host answers.
- R7: A block read returns first a count equal to the number of registers (16), then register 0 upward, one byte per host ACK; a host NACK ends the output and SDA stays released.
- R8: Data bytes aimed past the last register are acknowledged and discarded; a read past the last register returns 0xFF.
- R9: A stop condition returns the machine to idle and clears the command context to indexed mode at offset 0; register contents are kept.
- R10: A start condition in the middle of a byte abandons that byte and restarts the address phase; the partial byte is not stored.
- R11: The slave changes its SDA drive only in response to a falling SCL edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock level from the pad |
| sda_i | input | 1 | Bus data level from the pad |
| sda_oe | output | 1 | When 1 the pad pulls SDA low |
| regs_o | output | NREGS*8 | Register bank, byte k at bits 8k+7:8k |

## Verification
Two functions meet in one cycle when the last falling SCL edge of a data byte both writes the register bank and moves the machine into the acknowledge state, and when a start condition arrives while a byte is half shifted in. The bench provokes the first on every write, including writes past the last register where the acknowledge must appear but the bank must not change, and judges it from the sampled acknowledge bit and the parallel outputs. It provokes the second by breaking off an indexed write after four data bits with a new start, then checks that the abandoned register is untouched while the following transaction lands normally.

// File: rtl/smb_cfg_pkg.sv
package smb_cfg_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_CMD,
        ST_COUNT,
        ST_WDATA,
        ST_ACK,
        ST_TX,
        ST_MACK,
        ST_HOLD
    } smb_state_e;

    localparam int BYTE_BITS = 8;

endpackage

// File: rtl/smb_cfg_sync.sv
module smb_cfg_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_o,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_p,
    output logic stop_p
);

    logic [STAGES-1:0] scl_ff;
    logic [STAGES-1:0] sda_ff;
    logic              scl_d;
    logic              sda_d;
    logic              scl_q;
    logic              sda_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_ff <= '1;
            sda_ff <= '1;
            scl_d  <= 1'b1;
            sda_d  <= 1'b1;
        end else begin
            scl_ff <= {scl_ff[STAGES-2:0], scl_i};
            sda_ff <= {sda_ff[STAGES-2:0], sda_i};
            scl_d  <= scl_ff[STAGES-1];
            sda_d  <= sda_ff[STAGES-1];
        end
    end

    always_comb begin
        scl_q    = scl_ff[STAGES-1];
        sda_q    = sda_ff[STAGES-1];
        sda_o    = sda_q;
        scl_rise = scl_q & ~scl_d;
        scl_fall = ~scl_q & scl_d;
        start_p  = scl_q & scl_d & sda_d & ~sda_q;
        stop_p   = scl_q & scl_d & ~sda_d & sda_q;
    end

endmodule

// File: rtl/smb_cfg_regbank.sv
module smb_cfg_regbank #(
    parameter int NREGS = 16,
    parameter int AW    = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [AW-1:0]      wr_addr,
    input  logic [7:0]         wr_data,
    input  logic [AW-1:0]      rd_addr,
    output logic [7:0]         rd_data,
    output logic [NREGS*8-1:0] bank_o
);

    logic [7:0] mem [NREGS];

    for (genvar g = 0; g < NREGS; g++) begin : g_reg
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                mem[g] <= 8'h00;
            end else if (wr_en && (wr_addr == AW'(g))) begin
                mem[g] <= wr_data;
            end
        end
        assign bank_o[g*8 +: 8] = mem[g];
    end

    assign rd_data = mem[rd_addr];

endmodule

// File: rtl/smb_cfg_slave.sv
module smb_cfg_slave #(
    parameter logic [6:0] SLAVE_ADDR = 7'h2C,
    parameter int         NREGS      = 16,
    parameter int         SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               scl_i,
    input  logic               sda_i,
    output logic               sda_oe,
    output logic [NREGS*8-1:0] regs_o
);
    import smb_cfg_pkg::*;

    localparam int AW = (NREGS > 1) ? $clog2(NREGS) : 1;
    localparam int PW = 8;
    localparam logic [PW-1:0] PTR_MAX = '1;
    localparam logic [7:0]    COUNT_BYTE = 8'(NREGS);

    smb_state_e state, state_nx;
    smb_state_e after_ack, after_ack_nx;

    logic       sda_s, scl_rise, scl_fall, start_p, stop_p;
    logic [3:0] bitcnt, bitcnt_nx;
    logic [7:0] rxsh, rxsh_nx;
    logic [7:0] txsh, txsh_nx;
    logic [PW-1:0] ptr, ptr_nx;
    logic [PW-1:0] off, off_nx;
    logic       blk, blk_nx;
    logic       mack, mack_nx;
    logic       wr_en;
    logic [7:0] rd_data;
    logic [7:0] rd_byte;
    logic       in_range;
    logic       byte_done;

    smb_cfg_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_i    (scl_i),
        .sda_i    (sda_i),
        .sda_o    (sda_s),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall),
        .start_p  (start_p),
        .stop_p   (stop_p)
    );

    smb_cfg_regbank #(.NREGS(NREGS), .AW(AW)) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (ptr[AW-1:0]),
        .wr_data (rxsh),
        .rd_addr (ptr[AW-1:0]),
        .rd_data (rd_data),
        .bank_o  (regs_o)
    );

    assign in_range  = (ptr < PW'(NREGS));
    assign rd_byte   = in_range ? rd_data : 8'hFF;
    assign byte_done = scl_fall && (bitcnt == 4'd8);

    // next state and datapath decisions
    always_comb begin
        state_nx     = state;
        after_ack_nx = after_ack;
        bitcnt_nx    = bitcnt;
        rxsh_nx      = rxsh;
        txsh_nx      = txsh;
        ptr_nx       = ptr;
        off_nx       = off;
        blk_nx       = blk;
        mack_nx      = mack;
        wr_en        = 1'b0;
        if (stop_p) begin
            state_nx  = ST_IDLE;
            bitcnt_nx = '0;
            ptr_nx    = '0;
            off_nx    = '0;
            blk_nx    = 1'b0;
        end else if (start_p) begin
            state_nx  = ST_ADDR;
            bitcnt_nx = '0;
            ptr_nx    = off;
        end else begin
            unique case (state)
                ST_IDLE, ST_HOLD: begin
                end
                ST_ADDR, ST_CMD, ST_COUNT, ST_WDATA: begin
                    if (scl_rise) begin
                        rxsh_nx   = {rxsh[6:0], sda_s};
                        bitcnt_nx = bitcnt + 4'd1;
                    end else if (byte_done) begin
                        bitcnt_nx    = '0;
                        state_nx     = ST_ACK;
                        after_ack_nx = ST_WDATA;
                        if (state == ST_ADDR) begin
                            if (rxsh[7:1] != SLAVE_ADDR) begin
                                state_nx = ST_HOLD;
                            end else if (rxsh[0]) begin
                                after_ack_nx = ST_TX;
                                txsh_nx      = blk ? COUNT_BYTE : rd_byte;
                            end else begin
                                after_ack_nx = ST_CMD;
                            end
                        end else if (state == ST_CMD) begin
                            blk_nx = ~rxsh[7];
                            off_nx = rxsh[7] ? {1'b0, rxsh[6:0]} : '0;
                            ptr_nx = rxsh[7] ? {1'b0, rxsh[6:0]} : '0;
                            if (!rxsh[7]) begin
                                after_ack_nx = ST_COUNT;
                            end
                        end else if (state == ST_WDATA) begin
                            wr_en  = in_range;
                            ptr_nx = (ptr == PTR_MAX) ? ptr : ptr + 1'b1;
                        end
                    end
                end
                ST_ACK: begin
                    if (scl_fall) begin
                        state_nx  = after_ack;
                        bitcnt_nx = '0;
                    end
                end
                ST_TX: begin
                    if (scl_rise) begin
                        bitcnt_nx = bitcnt + 4'd1;
                    end else if (byte_done) begin
                        state_nx  = ST_MACK;
                        bitcnt_nx = '0;
                    end else if (scl_fall) begin
                        txsh_nx = {txsh[6:0], 1'b1};
                    end
                end
                ST_MACK: begin
                    if (scl_rise) begin
                        mack_nx = sda_s;
                    end else if (scl_fall) begin
                        if (!mack && blk) begin
                            state_nx = ST_TX;
                            txsh_nx  = rd_byte;
                            ptr_nx   = (ptr == PTR_MAX) ? ptr : ptr + 1'b1;
                        end else begin
                            state_nx = ST_HOLD;
                        end
                    end
                end
                default: state_nx = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            after_ack <= ST_IDLE;
        end else begin
            state     <= state_nx;
            after_ack <= after_ack_nx;
        end
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bitcnt <= '0;
            rxsh   <= '0;
            txsh   <= '1;
            ptr    <= '0;
            off    <= '0;
            blk    <= 1'b0;
            mack   <= 1'b1;
        end else begin
            bitcnt <= bitcnt_nx;
            rxsh   <= rxsh_nx;
            txsh   <= txsh_nx;
            ptr    <= ptr_nx;
            off    <= off_nx;
            blk    <= blk_nx;
            mack   <= mack_nx;
        end
    end

    // outputs: only ever pull low
    always_comb begin
        sda_oe = (state == ST_ACK) || ((state == ST_TX) && !txsh[7]);
    end

endmodule

// File: rtl/smb_cfg_slave_chk.sv
module smb_cfg_slave_chk #(
    parameter int NREGS = 16
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     sda_oe,
    input logic                     scl_fall,
    input logic                     start_p,
    input logic                     stop_p,
    input smb_cfg_pkg::smb_state_e  state,
    input logic [NREGS*8-1:0]       regs_o
);
    import smb_cfg_pkg::*;

    AST_OE_ON_SCL_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        (sda_oe != $past(sda_oe)) |-> $past(scl_fall)); // R11

    AST_STOP_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        stop_p |=> (state == ST_IDLE)); // R9

    AST_START_TO_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        (start_p && !stop_p) |=> (state == ST_ADDR)); // R10

    AST_HOLD_UNTIL_COND: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == ST_HOLD) && !start_p && !stop_p) |=> (state == ST_HOLD)); // R2

    AST_BANK_WRITE_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        (regs_o != $past(regs_o)) |-> ($past(state) == ST_WDATA)); // R3

endmodule

bind smb_cfg_slave smb_cfg_slave_chk #(.NREGS(NREGS)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .sda_oe   (sda_oe),
    .scl_fall (scl_fall),
    .start_p  (start_p),
    .stop_p   (stop_p),
    .state    (state),
    .regs_o   (regs_o)
);

// File: tb/smb_cfg_slave_bench.sv
`timescale 1ns/1ps
module smb_cfg_slave_bench;
    localparam logic [6:0] ADR = 7'h2C;
    localparam int NR = 16;
    localparam int Q  = 10;

    typedef struct {
        logic [7:0] d;
        string      tag;
    } item_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic m_scl = 1'b1;
    logic m_sda = 1'b1;
    logic sda_oe;
    logic sda_line;
    logic [NR*8-1:0] regs_o;
    logic [7:0] model [NR];
    item_t exp_q [$];
    logic [7:0] obs_val;
    event obs_ev;
    int n_chk = 0;
    int n_err = 0;
    logic ack;

    always #2 clk = ~clk;

    assign sda_line = m_sda & ~sda_oe;

    smb_cfg_slave #(.SLAVE_ADDR(ADR), .NREGS(NR)) u_smb_cfg_slave (
        .clk    (clk),
        .rst_n  (rst_n),
        .scl_i  (m_scl),
        .sda_i  (sda_line),
        .sda_oe (sda_oe),
        .regs_o (regs_o)
    );

    task automatic chk(string tag, logic [127:0] act, logic [127:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic logic [NR*8-1:0] flat();
        logic [NR*8-1:0] v;
        for (int i = 0; i < NR; i++) v[i*8 +: 8] = model[i];
        return v;
    endfunction

    // scoreboard monitor
    initial begin
        forever begin
            @(obs_ev);
            if (exp_q.size() == 0) begin
                chk("READ unexpected byte", 128'(obs_val), 128'hx);
            end else begin
                item_t it;
                it = exp_q.pop_front();
                chk(it.tag, 128'(obs_val), 128'(it.d));
            end
        end
    end

    task automatic expect_read(logic [7:0] d, string tag);
        item_t it;
        it.d = d;
        it.tag = tag;
        exp_q.push_back(it);
    endtask

    task automatic qw();
        repeat (Q) @(negedge clk);
    endtask

    task automatic bus_start();
        m_sda = 1'b1; qw();
        m_scl = 1'b1; qw();
        m_sda = 1'b0; qw();
        m_scl = 1'b0; qw();
    endtask

    task automatic bus_stop();
        m_sda = 1'b0; qw();
        m_scl = 1'b1; qw();
        m_sda = 1'b1; qw();
    endtask

    task automatic wbit(logic b);
        m_sda = b; qw();
        m_scl = 1'b1; qw(); qw();
        m_scl = 1'b0; qw();
    endtask

    task automatic rbit(output logic b);
        m_sda = 1'b1; qw();
        m_scl = 1'b1; qw();
        b = sda_line; qw();
        m_scl = 1'b0; qw();
    endtask

    task automatic wbyte(logic [7:0] d, output logic a);
        for (int i = 7; i >= 0; i--) wbit(d[i]);
        rbit(a);
    endtask

    task automatic rbyte(logic give_ack);
        logic [7:0] v;
        logic b;
        for (int i = 7; i >= 0; i--) begin
            rbit(b);
            v[i] = b;
        end
        obs_val = v;
        ->obs_ev;
        wbit(give_ack ? 1'b0 : 1'b1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        for (int i = 0; i < NR; i++) model[i] = 8'h00;
        repeat (8) @(negedge clk);
        rst_n = 1'b1;
        repeat (8) @(negedge clk);
        chk("R1 reset bank", 128'(regs_o), 128'(flat()));
        chk("R1 reset sda", 128'(sda_oe), 128'd0);

        // R3 byte write at offset 3
        bus_start();
        wbyte({ADR, 1'b0}, ack); chk("R2 address ack", 128'(ack), 128'd0);
        wbyte(8'h83, ack);
        wbyte(8'hA5, ack);       chk("R3 data ack", 128'(ack), 128'd0);
        bus_stop();
        model[3] = 8'hA5;
        chk("R3 byte write", 128'(regs_o), 128'(flat()));

        // R4 word write at offset 6
        bus_start();
        wbyte({ADR, 1'b0}, ack);
        wbyte(8'h86, ack);
        wbyte(8'h11, ack);
        wbyte(8'h22, ack);
        bus_stop();
        model[6] = 8'h11; model[7] = 8'h22;
        chk("R4 word write", 128'(regs_o), 128'(flat()));

        // R6 byte read of offset 3
        bus_start();
        wbyte({ADR, 1'b0}, ack);
        wbyte(8'h83, ack);
        bus_start();
        wbyte({ADR, 1'b1}, ack); chk("R6 read address ack", 128'(ack), 128'd0);
        expect_read(8'hA5, "R6 byte read");
        rbyte(1'b1);
        qw();
        chk("R6 released after byte", 128'(sda_oe), 128'd0);
        bus_stop();

        // R5 block write of three bytes, then stop
        bus_start();
        wbyte({ADR, 1'b0}, ack);
        wbyte(8'h00, ack);
        wbyte(8'h04, ack);       chk("R5 count ack", 128'(ack), 128'd0);
        for (int i = 0; i < 3; i++) wbyte(8'hC0 + 8'(i), ack);
        bus_stop();
        for (int i = 0; i < 3; i++) model[i] = 8'hC0 + 8'(i);
        chk("R5 block write", 128'(regs_o), 128'(flat()));

        // R7 block read: count then five bytes
        bus_start();
        wbyte({ADR, 1'b0}, ack);
        wbyte(8'h00, ack);
        bus_start();
        wbyte({ADR, 1'b1}, ack);
        expect_read(8'(NR), "R7 count byte");
        rbyte(1'b1);
        for (int i = 0; i < 5; i++) begin
            expect_read(model[i], "R7 block data");
            rbyte(i != 4);
        end
        qw();
        chk("R7 released after NACK", 128'(sda_oe), 128'd0);
        bus_stop();

        // R2 wrong address is ignored
        bus_start();
        wbyte({ADR ^ 7'h01, 1'b0}, ack); chk("R2 mismatch nack", 128'(ack), 128'd1);
        wbyte(8'h80, ack);               chk("R2 ignored cmd", 128'(ack), 128'd1);
        wbyte(8'hFF, ack);               chk("R2 ignored data", 128'(ack), 128'd1);
        bus_stop();
        chk("R2 bank unchanged", 128'(regs_o), 128'(flat()));

        // R8 word write straddling the end
        bus_start();
        wbyte({ADR, 1'b0}, ack);
        wbyte(8'h8F, ack);
        wbyte(8'h5A, ack);
        wbyte(8'h77, ack);       chk("R8 past-end ack", 128'(ack), 128'd0);
        bus_stop();
        model[15] = 8'h5A;
        chk("R8 past-end discard", 128'(regs_o), 128'(flat()));

        // R8 read past the end
        bus_start();
        wbyte({ADR, 1'b0}, ack);
        wbyte(8'hA0, ack);
        bus_start();
        wbyte({ADR, 1'b1}, ack);
        expect_read(8'hFF, "R8 past-end read");
        rbyte(1'b0);
        bus_stop();

        // R10 start in the middle of a data byte
        bus_start();
        wbyte({ADR, 1'b0}, ack);
        wbyte(8'h89, ack);
        for (int i = 0; i < 4; i++) wbit(1'b1);
        bus_start();
        wbyte({ADR, 1'b0}, ack);  chk("R10 readdress ack", 128'(ack), 128'd0);
        wbyte(8'h8A, ack);
        wbyte(8'h3C, ack);
        bus_stop();
        model[10] = 8'h3C;
        chk("R10 partial byte dropped", 128'(regs_o), 128'(flat()));

        // R9 context cleared by stop: read without command hits offset 0
        bus_start();
        wbyte({ADR, 1'b1}, ack);
        expect_read(model[0], "R9 offset reset");
        rbyte(1'b0);
        bus_stop();
        chk("R9 contents kept", 128'(regs_o), 128'(flat()));
        chk("R11 idle release", 128'(sda_oe), 128'd0);

        qw();
        chk("scoreboard drained", 128'(exp_q.size()), 128'd0);
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule